// File: doc/BRIEF.md
# Line Sensor Readout Controller

The controller runs on a system clock and drives one line sensor, or a chain of them, that shares a single sensor clock and a single reset/integration pulse. A divider makes the sensor clock from the system clock. A phase sequencer places both edges of the reset pulse on system-clock cycles where the sensor clock falls. The pulse is low while the video line is read out and high while the next line integrates. During the low phase a pixel counter emits a one-cycle sample strobe for every pixel, so that an external converter can capture the video level. The strobe carries the sensor number and the pixel number within that sensor, and a line-done pulse follows the last pixel of the last sensor.

Sensor falls are counted from the fall on which the reset pulse goes low, which is fall 0. Readout finishes at fall 4N+15, where N is the total pixel count. The low phase is never shorter than 4N+17 falls. The rising edge therefore always lands after the video period, and one full pulse cycle is never shorter than 16.5 + 4N sensor clocks. The integration request gives the high time in sensor clocks. Both phases have a floor set by a parameter, which is derived from the minimum pulse widths at the chosen clock rate. The configuration inputs are captured when the pulse falls, so each line runs with one consistent setting.

Top module: `lsens_readout`

## Requirements
- R1: The sensor clock `sns_clk` has a 50% duty cycle. Each of its high and low phases lasts exactly HALF_DIV system-clock cycles.
- R2: `sns_rst` changes only on a system-clock cycle on which `sns_clk` goes from 1 to 0.
- R3: `sns_rst` stays low for max(4N+17, MIN_LOW_CLKS) sensor-clock falls, so it never rises while pixels are still being strobed.
- R4: `sns_rst` stays high for max(integ_clks, MIN_HIGH_CLKS) sensor-clock falls.
- R5: Pixel k (0-based) of a line is strobed on sensor fall 19+4k, counted from the fall on which `sns_rst` went low (fall 0). Exactly N strobes are issued per line. Each strobe is one system cycle wide and coincides with a fall.
- R6: With P pixels per sensor, the strobe for pixel k reports `sens_idx` = k / P and `pix_idx` = k mod P, so chained sensors follow back to back. A sensor or pixel count of 0 is treated as 1.
- R7: `line_done` pulses for one system cycle, on the cycle right after the last strobe of a line, and once per line.
- R8: While `rst` is high or `en` is low, `sns_clk` is 0, `sns_rst` is 1, and `sample` and `line_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low returns the block to idle |
| integ_clks | input | INT_W | Requested high (integration) time in sensor clocks |
| num_sensors | input | SENS_W | Number of chained sensors |
| pix_per_sensor | input | PIX_W | Pixels in each sensor |
| sns_clk | output | 1 | Sensor clock |
| sns_rst | output | 1 | Reset/integration pulse to the sensors |
| sample | output | 1 | One-cycle converter sample strobe |
| sens_idx | output | SENS_W | Sensor number of the strobed pixel |
| pix_idx | output | PIX_W | Pixel number within that sensor |
| line_done | output | 1 | Pulse after the last pixel of a line |

## Verification
The bench runs the controller with a short divider and small phase floors over a set of chain shapes. The set covers a single one-pixel sensor, a single wider sensor, two and three chained sensors, and zero counts that must act as one. This separates index wrap-around errors, which only show when more than one sensor is chained, from strobe placement errors, which show even with one pixel. The integration request is chosen once below the high-phase floor and once well above it. The low-phase length is tested both where the MIN_LOW_CLKS floor wins and where the video length wins. These cases tell a missing clamp apart from a wrong pixel-count formula. Each configuration runs several lines and then returns to idle, so the bench also checks reconfiguration and the return to the quiet state.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } lsr_phase_t;

  // Sensor-clock falls from the reset fall to the first strobe.
  localparam int FIRST_SAMPLE_FALL = 19;
  // Sensor-clock falls between consecutive pixel strobes.
  localparam int SAMPLE_STEP = 4;
  // Fixed term of the low-phase length (4*N + VIDEO_TAIL).
  localparam int VIDEO_TAIL = 17;
endpackage

// File: rtl/lsr_clkgen.sv
module lsr_clkgen #(
  parameter int HALF_DIV = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sns_clk,
  output logic fall_tick
);
  localparam int DIV_W = $clog2(HALF_DIV + 1);

  logic [DIV_W-1:0] div_cnt;
  logic             wrap;

  assign wrap      = (div_cnt == DIV_W'(HALF_DIV - 1));
  assign fall_tick = run && wrap && sns_clk;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      div_cnt <= '0;
      sns_clk <= 1'b0;
    end else if (wrap) begin
      div_cnt <= '0;
      sns_clk <= ~sns_clk;
    end else begin
      div_cnt <= div_cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/lsr_phase_seq.sv
module lsr_phase_seq
  import lsr_pkg::*;
#(
  parameter int LEN_W         = 20,
  parameter int MIN_LOW_CLKS  = 20,
  parameter int MIN_HIGH_CLKS = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             fall_tick,
  input  logic [LEN_W-1:0] video_len,
  input  logic [LEN_W-1:0] integ_len,
  output logic             sns_rst,
  output logic             line_start
);
  lsr_phase_t       phase;
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] low_len;
  logic [LEN_W-1:0] high_len;
  logic [LEN_W-1:0] next_low;
  logic [LEN_W-1:0] next_high;
  logic             cnt_hit_low;
  logic             cnt_hit_high;

  // Clamp requested phase lengths to their floors.
  assign next_low  = (video_len > LEN_W'(MIN_LOW_CLKS))  ? video_len : LEN_W'(MIN_LOW_CLKS);
  assign next_high = (integ_len > LEN_W'(MIN_HIGH_CLKS)) ? integ_len : LEN_W'(MIN_HIGH_CLKS);

  assign cnt_hit_low  = (cnt + LEN_W'(1)) == low_len;
  assign cnt_hit_high = (cnt + LEN_W'(1)) == high_len;

  assign line_start = fall_tick &&
                      ((phase == PH_IDLE) || ((phase == PH_HIGH) && cnt_hit_high));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      low_len  <= LEN_W'(MIN_LOW_CLKS);
      high_len <= LEN_W'(MIN_HIGH_CLKS);
      sns_rst  <= 1'b1;
    end else if (line_start) begin
      phase    <= PH_LOW;
      cnt      <= '0;
      low_len  <= next_low;
      high_len <= next_high;
      sns_rst  <= 1'b0;
    end else if (fall_tick) begin
      if ((phase == PH_LOW) && cnt_hit_low) begin
        phase   <= PH_HIGH;
        cnt     <= '0;
        sns_rst <= 1'b1;
      end else begin
        cnt <= cnt + LEN_W'(1);
      end
    end
  end
endmodule

// File: rtl/lsr_pix_counter.sv
module lsr_pix_counter
  import lsr_pkg::*;
#(
  parameter int SENS_W = 3,
  parameter int PIX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              fall_tick,
  input  logic              line_start,
  input  logic [SENS_W-1:0] sens_cnt,
  input  logic [PIX_W-1:0]  pix_cnt,
  output logic              busy,
  output logic              sample,
  output logic [SENS_W-1:0] sens_idx,
  output logic [PIX_W-1:0]  pix_idx,
  output logic              line_done
);
  localparam int WAIT_W = $clog2(FIRST_SAMPLE_FALL + 1);

  logic [WAIT_W-1:0] wait_cnt;
  logic [SENS_W-1:0] cur_sens;
  logic [PIX_W-1:0]  cur_pix;
  logic [SENS_W-1:0] last_sens;
  logic [PIX_W-1:0]  last_pix;
  logic              done_arm;
  logic              last_in_sens;

  assign last_in_sens = (cur_pix == last_pix);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      busy      <= 1'b0;
      wait_cnt  <= '0;
      cur_sens  <= '0;
      cur_pix   <= '0;
      last_sens <= '0;
      last_pix  <= '0;
      sample    <= 1'b0;
      sens_idx  <= '0;
      pix_idx   <= '0;
      done_arm  <= 1'b0;
      line_done <= 1'b0;
    end else begin
      sample    <= 1'b0;
      done_arm  <= 1'b0;
      line_done <= done_arm;
      if (line_start) begin
        busy      <= 1'b1;
        wait_cnt  <= WAIT_W'(FIRST_SAMPLE_FALL);
        cur_sens  <= '0;
        cur_pix   <= '0;
        last_sens <= sens_cnt - SENS_W'(1);
        last_pix  <= pix_cnt - PIX_W'(1);
      end else if (fall_tick && busy) begin
        if (wait_cnt == WAIT_W'(1)) begin
          sample   <= 1'b1;
          sens_idx <= cur_sens;
          pix_idx  <= cur_pix;
          wait_cnt <= WAIT_W'(SAMPLE_STEP);
          if (last_in_sens) begin
            cur_pix <= '0;
            if (cur_sens == last_sens) begin
              busy     <= 1'b0;
              done_arm <= 1'b1;
            end else begin
              cur_sens <= cur_sens + SENS_W'(1);
            end
          end else begin
            cur_pix <= cur_pix + PIX_W'(1);
          end
        end else begin
          wait_cnt <= wait_cnt - WAIT_W'(1);
        end
      end
    end
  end

  // R7: the line-done pulse directly follows a strobe
  a_r7_done_follows_sample: assert property (@(posedge clk) disable iff (rst)
    line_done |-> $past(sample));

  // R7: a line-done pulse lasts one cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    line_done |=> !line_done);
endmodule

// File: rtl/lsens_readout.sv
module lsens_readout
  import lsr_pkg::*;
#(
  parameter int HALF_DIV      = 25,
  parameter int SENS_W        = 3,
  parameter int PIX_W         = 8,
  parameter int INT_W         = 16,
  parameter int MIN_LOW_CLKS  = 20,
  parameter int MIN_HIGH_CLKS = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [INT_W-1:0]  integ_clks,
  input  logic [SENS_W-1:0] num_sensors,
  input  logic [PIX_W-1:0]  pix_per_sensor,
  output logic              sns_clk,
  output logic              sns_rst,
  output logic              sample,
  output logic [SENS_W-1:0] sens_idx,
  output logic [PIX_W-1:0]  pix_idx,
  output logic              line_done
);
  localparam int NPIX_W = SENS_W + PIX_W;
  localparam int VID_W  = NPIX_W + 3;
  localparam int LEN_W  = ((VID_W > INT_W) ? VID_W : INT_W) + 1;

  logic              fall_tick;
  logic              line_start;
  logic              busy;
  logic [SENS_W-1:0] sens_eff;
  logic [PIX_W-1:0]  pix_eff;
  logic [NPIX_W-1:0] total_pix;
  logic [LEN_W-1:0]  video_len;
  logic [LEN_W-1:0]  integ_len;

  assign sens_eff  = (num_sensors == '0) ? SENS_W'(1) : num_sensors;
  assign pix_eff   = (pix_per_sensor == '0) ? PIX_W'(1) : pix_per_sensor;
  assign total_pix = NPIX_W'(sens_eff) * NPIX_W'(pix_eff);
  assign video_len = (LEN_W'(total_pix) << 2) + LEN_W'(VIDEO_TAIL);
  assign integ_len = LEN_W'(integ_clks);

  lsr_clkgen #(
    .HALF_DIV (HALF_DIV)
  ) u_clkgen (
    .clk       (clk),
    .rst       (rst),
    .run       (en),
    .sns_clk   (sns_clk),
    .fall_tick (fall_tick)
  );

  lsr_phase_seq #(
    .LEN_W         (LEN_W),
    .MIN_LOW_CLKS  (MIN_LOW_CLKS),
    .MIN_HIGH_CLKS (MIN_HIGH_CLKS)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .run        (en),
    .fall_tick  (fall_tick),
    .video_len  (video_len),
    .integ_len  (integ_len),
    .sns_rst    (sns_rst),
    .line_start (line_start)
  );

  lsr_pix_counter #(
    .SENS_W (SENS_W),
    .PIX_W  (PIX_W)
  ) u_pix (
    .clk        (clk),
    .rst        (rst),
    .run        (en),
    .fall_tick  (fall_tick),
    .line_start (line_start),
    .sens_cnt   (sens_eff),
    .pix_cnt    (pix_eff),
    .busy       (busy),
    .sample     (sample),
    .sens_idx   (sens_idx),
    .pix_idx    (pix_idx),
    .line_done  (line_done)
  );

  // R2: reset pulse edges only where the sensor clock falls
  a_r2_edge_on_fall: assert property (@(posedge clk) disable iff (rst || !en)
    (sns_rst != $past(sns_rst)) |-> $fell(sns_clk));

  // R3: the rising edge never lands inside readout
  a_r3_rise_after_video: assert property (@(posedge clk) disable iff (rst)
    $rose(sns_rst) |-> !busy);

  // R5: strobes coincide with a sensor-clock fall
  a_r5_sample_on_fall: assert property (@(posedge clk) disable iff (rst)
    sample |-> $fell(sns_clk));

  // R5: strobes are issued only during the low phase
  a_r5_sample_in_low: assert property (@(posedge clk) disable iff (rst)
    sample |-> !sns_rst);

  // R8: dropping the enable quiets the outputs
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!sample && !line_done && sns_rst && !sns_clk));
endmodule

// File: tb/lsens_readout_test.sv
module lsens_readout_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 2;
  localparam int SW         = 3;
  localparam int PW         = 8;
  localparam int IW         = 16;
  localparam int MIN_LOW    = 30;
  localparam int MIN_HIGH   = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en  = 1'b0;
  logic [IW-1:0] integ_clks = '0;
  logic [SW-1:0] num_sensors = '0;
  logic [PW-1:0] pix_per_sensor = '0;
  logic          sns_clk, sns_rst, sample, line_done;
  logic [SW-1:0] sens_idx;
  logic [PW-1:0] pix_idx;

  int checks = 0;
  int failures = 0;

  // monitor state
  bit mon = 1'b0;
  bit p_clk, p_rst, p_sample, seen_edge, in_line;
  int ph_cnt, fc, k, dones, starts;
  int exp_n, exp_p, exp_low, exp_high;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsens_readout #(
    .HALF_DIV      (HALF),
    .SENS_W        (SW),
    .PIX_W         (PW),
    .INT_W         (IW),
    .MIN_LOW_CLKS  (MIN_LOW),
    .MIN_HIGH_CLKS (MIN_HIGH)
  ) uut (
    .clk            (clk),
    .rst            (rst),
    .en             (en),
    .integ_clks     (integ_clks),
    .num_sensors    (num_sensors),
    .pix_per_sensor (pix_per_sensor),
    .sns_clk        (sns_clk),
    .sns_rst        (sns_rst),
    .sample         (sample),
    .sens_idx       (sens_idx),
    .pix_idx        (pix_idx),
    .line_done      (line_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(negedge clk) begin
    if (mon) begin
      bit fell;
      fell = p_clk && !sns_clk;
      // R1: phase length of the sensor clock
      if (sns_clk != p_clk) begin
        if (seen_edge) chk(ph_cnt == HALF - 1, "R1 phase cycles", ph_cnt + 1, HALF);
        seen_edge = 1'b1;
        ph_cnt = 0;
      end else begin
        ph_cnt++;
      end
      if (sns_rst != p_rst) chk(fell, "R2 edge off fall", int'(fell), 1);
      if (fell) fc++;
      if (sns_rst && !p_rst) begin
        chk(fc == exp_low, "R3 low length", fc, exp_low);
        fc = 0;
      end
      if (!sns_rst && p_rst) begin
        if (in_line) begin
          chk(fc == exp_high, "R4 high length", fc, exp_high);
          chk(k == exp_n, "R5 strobes per line", k, exp_n);
          chk(dones == 1, "R7 done count", dones, 1);
        end
        in_line = 1'b1;
        starts++;
        fc = 0;
        k = 0;
        dones = 0;
      end
      if (sample) begin
        chk(fell, "R5 strobe off fall", int'(fell), 1);
        chk(fc == 19 + 4 * k, "R5 strobe fall", fc, 19 + 4 * k);
        chk(int'(sens_idx) == k / exp_p, "R6 sens_idx", int'(sens_idx), k / exp_p);
        chk(int'(pix_idx) == k % exp_p, "R6 pix_idx", int'(pix_idx), k % exp_p);
        k++;
      end
      if (line_done) begin
        chk(p_sample && k == exp_n, "R7 done timing", k, exp_n);
        dones++;
      end
      p_clk = sns_clk;
      p_rst = sns_rst;
      p_sample = sample;
    end
  end

  task automatic run_cfg(input int ns, input int pp, input int integ);
    int nse, ppe, vid;
    nse = (ns == 0) ? 1 : ns;
    ppe = (pp == 0) ? 1 : pp;
    exp_p = ppe;
    exp_n = nse * ppe;
    vid = 4 * exp_n + 17;
    exp_low = (vid > MIN_LOW) ? vid : MIN_LOW;
    exp_high = (integ > MIN_HIGH) ? integ : MIN_HIGH;
    @(negedge clk);
    num_sensors = SW'(ns);
    pix_per_sensor = PW'(pp);
    integ_clks = IW'(integ);
    p_clk = 1'b0;
    p_rst = 1'b1;
    p_sample = 1'b0;
    seen_edge = 1'b0;
    in_line = 1'b0;
    ph_cnt = 0;
    fc = 0;
    k = 0;
    dones = 0;
    starts = 0;
    en = 1'b1;
    mon = 1'b1;
    while (starts < 4) @(posedge clk);
    @(posedge clk);
    mon = 1'b0;
    @(negedge clk);
    en = 1'b0;
    repeat (3) @(negedge clk);
    // R8: back to idle after enable drops
    chk(!sns_clk && sns_rst && !sample && !line_done, "R8 idle after disable",
        int'({sns_clk, sns_rst, sample, line_done}), 4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R8: state under reset
    chk(!sns_clk && sns_rst && !sample && !line_done, "R8 reset state",
        int'({sns_clk, sns_rst, sample, line_done}), 4);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(!sns_clk && sns_rst, "R8 idle with enable low", int'({sns_clk, sns_rst}), 1);
    run_cfg(1, 1, 2);    // floor on both phases
    run_cfg(1, 4, 40);   // long integration
    run_cfg(2, 3, 7);    // chained, video length wins over low floor
    run_cfg(3, 4, 5);    // three sensors
    run_cfg(2, 0, 9);    // zero pixels act as one
    run_cfg(0, 5, 12);   // zero sensors act as one
    summary();
    $finish;
  end
endmodule